// File: doc/BRIEF.md
# Camera YUV 4:2:0 Tile Packer

This block sits behind a camera receiver. It takes an 8-bit YUV 4:2:2 byte stream and repacks it into 48-byte chunks. Each chunk covers a tile 16 pixels wide and two rows tall. Input bytes are qualified by a byte strobe and a line-valid level, and a frame-start pulse marks the beginning of each frame.

The block works on pairs of rows. The first (upper) row of each pair is written into a line store sized by the `WIDTH` parameter. While the second (lower) row streams in, its luma is gathered one tile at a time. When a tile's last lower byte arrives, the chunk is assembled in a single cycle and queued in a small chunk FIFO. The FIFO then drains the chunk one byte at a time through a valid/ready output.

Chroma is decimated to 4:2:0 by keeping the upper row's samples. Every row inside a chunk, whether luma or chroma, is laid out right to left.

Top module: `yuv_tile_packer`

## Requirements
- R1: After reset, `out_valid_o`, `len_err_o` and `overflow_o` are all low.
- R2: Chunk bytes 0..15 hold the upper row's luma for the tile's 16 pixels in reverse order. Byte 0 is the rightmost pixel of the tile.
- R3: Chunk bytes 16..31 hold the lower row's luma for the same 16 pixels, also in reverse order.
- R4: Chunk bytes 32..39 hold the tile's 8 U samples and bytes 40..47 hold its 8 V samples, each group right to left. All of them are taken from the upper row; the lower row's chroma bytes have no effect on the output.
- R5: Input bytes arrive in the repeating order Y(even pixel), U, Y(odd pixel), V, counted only while both `pix_valid_i` and `line_valid_i` are high. Chunks of a row pair appear left to right, one per tile, and nothing is emitted for an upper row alone.
- R6: A `frame_start_i` pulse clears the byte count and row parity, so the next line is taken as an upper row.
- R7: A line whose length differs from 2*WIDTH bytes sets the sticky `len_err_o`. Bytes beyond 2*WIDTH are ignored. The next line is taken as an upper row, so a bad upper row produces no chunk.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold. No byte is lost or repeated.
- R9: A tile that completes while the FIFO holds DEPTH chunks is dropped and sets the sticky `overflow_o`. The chunks already queued are delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input byte strobe |
| pix_data_i | input | 8 | Input YUV 4:2:2 byte |
| line_valid_i | input | 1 | High for the duration of a camera line |
| frame_start_i | input | 1 | One-cycle pulse at frame start |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output chunk byte |
| out_ready_i | input | 1 | Downstream ready |
| len_err_o | output | 1 | Sticky line-length error |
| overflow_o | output | 1 | Sticky chunk-drop flag |

## Verification
The assertions assume two things about the inputs. First, `frame_start_i` is pulsed only while `line_valid_i` is low. Second, the input byte rate leaves the output time to drain, because each lower row turns 2*WIDTH input bytes into 3*WIDTH output bytes. The stimulus keeps to both. It pulses frame start between lines only, and in the random-backpressure phase it inserts idle cycles between bytes. FIFO overflow is reached only on purpose, by holding ready low across two row pairs.

// File: rtl/yuv_pkg.sv
package yuv_pkg;
  localparam int TILE_PIX    = 16;
  localparam int TILE_CHROMA = TILE_PIX / 2;
  localparam int CHUNK_BYTES = 3 * TILE_PIX;

  typedef logic [CHUNK_BYTES-1:0][7:0] chunk_t;
  typedef logic [TILE_PIX-1:0][7:0]    luma_row_t;
  typedef logic [TILE_CHROMA-1:0][7:0] chroma_row_t;

  typedef enum logic [1:0] {PH_Y0, PH_U, PH_Y1, PH_V} phase_e;
endpackage

// File: rtl/yuv_line_store.sv
module yuv_line_store
  import yuv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                            clk_i,
  input  logic                            wr_en_i,
  input  logic [$clog2(2*WIDTH)-1:0]      wr_idx_i,
  input  logic [7:0]                      wr_data_i,
  input  logic [((WIDTH/TILE_PIX)>1 ? $clog2(WIDTH/TILE_PIX) : 1)-1:0] rd_tile_i,
  output luma_row_t                       up_y_o,
  output chroma_row_t                     up_u_o,
  output chroma_row_t                     up_v_o
);
  localparam int IDX_W = $clog2(2*WIDTH);
  localparam int Y_AW  = IDX_W - 1;
  localparam int C_AW  = IDX_W - 2;

  logic [7:0] ybuf [WIDTH];
  logic [7:0] ubuf [WIDTH/2];
  logic [7:0] vbuf [WIDTH/2];

  phase_e wr_ph;
  assign wr_ph = phase_e'(wr_idx_i[1:0]);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      unique case (wr_ph)
        PH_Y0, PH_Y1: ybuf[wr_idx_i[IDX_W-1:1]] <= wr_data_i;
        PH_U:         ubuf[wr_idx_i[IDX_W-1:2]] <= wr_data_i;
        PH_V:         vbuf[wr_idx_i[IDX_W-1:2]] <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < TILE_PIX; i++)
      up_y_o[i] = ybuf[Y_AW'(int'(rd_tile_i) * TILE_PIX + i)];
    for (int j = 0; j < TILE_CHROMA; j++) begin
      up_u_o[j] = ubuf[C_AW'(int'(rd_tile_i) * TILE_CHROMA + j)];
      up_v_o[j] = vbuf[C_AW'(int'(rd_tile_i) * TILE_CHROMA + j)];
    end
  end
endmodule

// File: rtl/yuv_chunk_fifo.sv
module yuv_chunk_fifo
  import yuv_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  chunk_t     chunk_i,
  output logic       full_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  input  logic       out_ready_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BI_W  = $clog2(CHUNK_BYTES);

  chunk_t             mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic [BI_W-1:0]    byte_idx;
  logic               pop_byte, pop_chunk;

  assign full_o      = (count == CNT_W'(DEPTH));
  assign out_valid_o = (count != '0);
  assign out_data_o  = mem[rd_ptr][byte_idx];
  assign pop_byte    = out_valid_o & out_ready_i;
  assign pop_chunk   = pop_byte & (byte_idx == BI_W'(CHUNK_BYTES - 1));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= chunk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      byte_idx <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_chunk) begin
        rd_ptr   <= nxt(rd_ptr);
        byte_idx <= '0;
      end else if (pop_byte) begin
        byte_idx <= byte_idx + 1'b1;
      end
      count <= count + CNT_W'(push_i) - CNT_W'(pop_chunk);
    end
  end

  // R8: a stalled byte must not change
  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R9: the producer must gate pushes on full
  a_r9_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count < CNT_W'(DEPTH));

  // R5: a chunk leaves only after its last byte is taken
  a_r5_chunk_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !(pop_byte && byte_idx == BI_W'(CHUNK_BYTES - 1)) |=> out_valid_o);
endmodule

// File: rtl/yuv_tile_packer.sv
module yuv_tile_packer
  import yuv_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_valid_i,
  input  logic [7:0] pix_data_i,
  input  logic       line_valid_i,
  input  logic       frame_start_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  input  logic       out_ready_i,
  output logic       len_err_o,
  output logic       overflow_o
);
  localparam int LINE_BYTES = 2 * WIDTH;
  localparam int TILES      = WIDTH / TILE_PIX;
  localparam int CNT_W      = $clog2(LINE_BYTES + 1);
  localparam int IDX_W      = $clog2(LINE_BYTES);
  localparam int TILE_W     = (TILES > 1) ? $clog2(TILES) : 1;

  logic             lv_q, odd_q, over_q, len_err_q, ovf_q;
  logic [CNT_W-1:0] cnt_q;
  luma_row_t        low_y_q;
  logic             acc, line_end, tile_done, fifo_full;
  luma_row_t        up_y;
  chroma_row_t      up_u, up_v;
  chunk_t           chunk;

  assign acc       = pix_valid_i & line_valid_i & (cnt_q < CNT_W'(LINE_BYTES));
  assign line_end  = lv_q & ~line_valid_i;
  // last byte (V) of a 16-pixel group on the lower row
  assign tile_done = acc & odd_q & (cnt_q[4:0] == 5'd31);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q      <= 1'b0;
      odd_q     <= 1'b0;
      over_q    <= 1'b0;
      len_err_q <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      lv_q <= line_valid_i;
      if (frame_start_i) begin
        cnt_q  <= '0;
        odd_q  <= 1'b0;
        over_q <= 1'b0;
      end else if (line_end) begin
        cnt_q  <= '0;
        over_q <= 1'b0;
        if (over_q || cnt_q != CNT_W'(LINE_BYTES)) begin
          len_err_q <= 1'b1;
          odd_q     <= 1'b0;
        end else begin
          odd_q <= ~odd_q;
        end
      end else begin
        if (acc) cnt_q <= cnt_q + 1'b1;
        if (pix_valid_i && line_valid_i && !acc) over_q <= 1'b1;
      end
      if (tile_done && fifo_full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_y_q <= '0;
    else if (acc && odd_q && !cnt_q[0]) low_y_q[cnt_q[4:1]] <= pix_data_i;
  end

  yuv_line_store #(.WIDTH(WIDTH)) u_line_store (
    .clk_i    (clk_i),
    .wr_en_i  (acc & ~odd_q),
    .wr_idx_i (cnt_q[IDX_W-1:0]),
    .wr_data_i(pix_data_i),
    .rd_tile_i(TILE_W'(cnt_q >> 5)),
    .up_y_o   (up_y),
    .up_u_o   (up_u),
    .up_v_o   (up_v)
  );

  always_comb begin
    for (int k = 0; k < TILE_PIX; k++) begin
      chunk[k]            = up_y[TILE_PIX-1-k];
      chunk[TILE_PIX + k] = low_y_q[TILE_PIX-1-k];
    end
    for (int j = 0; j < TILE_CHROMA; j++) begin
      chunk[2*TILE_PIX + j]               = up_u[TILE_CHROMA-1-j];
      chunk[2*TILE_PIX + TILE_CHROMA + j] = up_v[TILE_CHROMA-1-j];
    end
  end

  yuv_chunk_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (tile_done & ~fifo_full),
    .chunk_i    (chunk),
    .full_o     (fifo_full),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_ready_i(out_ready_i)
  );

  assign len_err_o  = len_err_q;
  assign overflow_o = ovf_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |=> len_err_o);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LINE_BYTES));

  // R5: nothing is emitted while only upper rows have been seen since reset
  a_r5_no_out_before_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o && !odd_q |=> !out_valid_o);
endmodule

// File: tb/yuv_tile_packer_bench.sv
module yuv_tile_packer_bench;
  localparam int W      = 32;
  localparam int D      = 2;
  localparam int TILES  = W / 16;
  localparam int LBYTES = 2 * W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic       line_valid = 1'b0;
  logic       frame_start = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       len_err, overflow;

  int         n_tests = 0;
  int         n_fail  = 0;
  logic [7:0] exp_q[$];
  int         ready_mode = 0;
  int         rx_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #10 clk = ~clk;

  yuv_tile_packer #(.WIDTH(W), .DEPTH(D)) u_yuv_tile_packer (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .line_valid_i(line_valid), .frame_start_i(frame_start),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .len_err_o(len_err), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int idx);
    return 8'(seed * 29 + idx * 7 + (idx >> 2) * 13 + 5);
  endfunction

  // R2 R3 R4: expected chunk contents for one row pair
  task automatic expect_pair(input int su, input int sl);
    for (int t = 0; t < TILES; t++) begin
      for (int k = 0; k < 16; k++) exp_q.push_back(bval(su, 2 * (t * 16 + 15 - k)));
      for (int k = 0; k < 16; k++) exp_q.push_back(bval(sl, 2 * (t * 16 + 15 - k)));
      for (int j = 0; j < 8; j++)  exp_q.push_back(bval(su, 4 * (t * 8 + 7 - j) + 1));
      for (int j = 0; j < 8; j++)  exp_q.push_back(bval(su, 4 * (t * 8 + 7 - j) + 3));
    end
  endtask

  task automatic send_line(input int seed, input int len, input int gap);
    @(negedge clk);
    line_valid = 1'b1;
    for (int i = 0; i < len; i++) begin
      pix_valid = 1'b1;
      pix_data  = bval(seed, i);
      @(negedge clk);
      pix_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    line_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_pair(input int su, input int sl, input int gap);
    expect_pair(su, sl);
    send_line(su, LBYTES, gap);
    send_line(sl, LBYTES, gap);
  endtask

  task automatic drain();
    for (int g = 0; g < 5000 && exp_q.size() != 0; g++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected bytes delivered", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R5 no surplus output", out_valid, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(len_err == 1'b0, "R1 len_err after reset", len_err, 0);
    chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
  endtask

  // scoreboard monitor; owns out_ready
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (lfsr[1:0] != 2'b00);
        default: out_ready = 1'b0;
      endcase
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8 stalled byte held", out_data, prev_data);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected output byte", out_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (rx_cnt % 48 < 16)      chk(out_data == e, "R2 upper luma byte", out_data, e);
          else if (rx_cnt % 48 < 32) chk(out_data == e, "R3 lower luma byte", out_data, e);
          else                       chk(out_data == e, "R4 chroma byte", out_data, e);
        end
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R2 R3 R4 R5: basic packing, back-to-back and gapped input
    send_pair(1, 2, 0);
    send_pair(3, 4, 1);
    drain();

    // R6: an orphan upper row is discarded by frame start
    send_line(9, LBYTES, 0);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    send_pair(5, 6, 0);
    drain();
    chk(len_err == 1'b0, "R7 no error on correct lines", len_err, 0);

    // R8: random backpressure
    ready_mode = 1;
    send_pair(7, 8, 2);
    send_pair(10, 11, 2);
    drain();
    ready_mode = 0;

    // R7: short line, then overlong line
    send_line(12, 20, 0);
    chk(len_err == 1'b1, "R7 short line flags error", len_err, 1);
    send_pair(13, 14, 0);
    drain();
    send_line(15, LBYTES + 6, 0);
    send_pair(16, 17, 0);
    drain();
    chk(len_err == 1'b1, "R7 error stays set", len_err, 1);

    // R9: overflow with ready held low
    do_reset();
    rx_cnt = 0;
    ready_mode = 2;
    send_pair(18, 19, 0);
    chk(overflow == 1'b0, "R9 no overflow while room", overflow, 0);
    send_line(20, LBYTES, 0);
    send_line(21, LBYTES, 0);
    chk(overflow == 1'b1, "R9 overflow flagged", overflow, 1);
    chk(out_valid == 1'b1, "R9 queued chunks waiting", out_valid, 1);
    ready_mode = 0;
    drain();
    chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule